// File: doc/BRIEF.md
# Parallel Flash Command Interpreter

This block is a behavioural model of the command front end of a byte-wide parallel flash device. A host on a simple synchronous bus (address, write data, write strobe, read strobe, registered read data) writes command bytes. The block decodes them and switches what reads return: the stored array, identification bytes, or a status byte. It also runs two-write operations: a sector erase, and a single-byte program that only clears bits.

While an operation runs, an internal busy timer holds the ready flag low for a parameterised number of cycles. During that time every read returns the status byte and every write is dropped. An erase setup that is not confirmed correctly aborts and sets both error flags. The error flags stay set until the host writes the clear command. The storage is a small register array that comes out of reset fully erased.

Top module: `flash_cmd_ui`

## Requirements
- R1: After reset the block is in array mode with rdata = 0x00. Every array byte reads 0xFF, and the status byte is 0x80.
- R2: Writing 0xFF to any address while the block accepts commands selects array mode. In array mode a read returns the byte stored at the read address.
- R3: Writing 0x90 selects identification mode. A read at address 0 returns MFR_ID and a read at address 1 returns DEV_ID. A read at any other address returns 0x00.
- R4: Writing 0x70 selects status mode. The status byte places ready (not busy) in bit 7, the erase error flag in bit 6 and the program error flag in bit 1, and holds 0 in all other bits. Reads also return the status byte in the two setup states.
- R5: Writing 0x30 and then 0xD0 erases the whole sector holding the address of the 0xD0 write. A sector is the set of addresses sharing bits [ADDR_W-1:SECT_W]. Every byte of that sector becomes 0xFF, and bytes in other sectors are unchanged.
- R6: Writing 0x10 and then any write stores (old byte AND written data) at that write's address.
- R7: After the program write, bit 7 of the status byte stays 0 for exactly PROG_CYC cycles. After the erase confirm it stays 0 for exactly ERASE_CYC cycles. When either operation starts, the block enters status mode.
- R8: While busy, a read at any address returns the status byte, and every write is ignored. This includes a write in the last busy cycle.
- R9: After 0x30, a write of any byte other than 0xD0 aborts the erase. It sets both error flags, erases nothing, and selects status mode.
- R10: Error flags stay set across later operations until 0x50 is written while not busy. Writing 0x50 clears both flags and leaves the read mode unchanged.
- R11: A command byte outside {0xFF, 0x90, 0x70, 0x50, 0x30, 0x10}, written while not busy and not in a setup state, changes nothing.
- R12: When rd_en and wr_en are high in the same cycle, the read returns the view from before that write.
- R13: rdata changes only in a cycle with rd_en high, and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Byte address for reads and writes |
| wdata | input | 8 | Write data or command byte |
| wr_en | input | 1 | Write strobe, one write per cycle |
| rd_en | input | 1 | Read strobe; rdata updates at the next edge |
| rdata | output | 8 | Registered read data |

## Verification
Two functions can land on the same edge. One is the busy timer expiring while a command write arrives. The other is a read issued in the same cycle as a command write. For the first, the bench issues a program, idles exactly PROG_CYC-1 cycles and then writes 0x90. That write falls in the last busy cycle and must be dropped, so a following read at address 1 still returns status. A second 0x90 one cycle later must take effect. For the second, the bench drives a read together with a mode-changing write and expects the pre-write view. A behavioural model in the bench predicts rdata on every clock.

// File: rtl/fcu_pkg.sv
package fcu_pkg;
   typedef enum logic [2:0] {
      M_ARRAY     = 3'd0,
      M_ID        = 3'd1,
      M_STATUS    = 3'd2,
      M_ERS_SETUP = 3'd3,
      M_PRG_SETUP = 3'd4
   } mode_e;

   localparam logic [7:0] CMD_TO_ARRAY  = 8'hFF;
   localparam logic [7:0] CMD_TO_ID     = 8'h90;
   localparam logic [7:0] CMD_TO_STATUS = 8'h70;
   localparam logic [7:0] CMD_CLR_ERR   = 8'h50;
   localparam logic [7:0] CMD_ERS_SETUP = 8'h30;
   localparam logic [7:0] CMD_ERS_CONF  = 8'hD0;
   localparam logic [7:0] CMD_PRG_SETUP = 8'h10;
endpackage

// File: rtl/fcu_cmd_dec.sv
module fcu_cmd_dec
   import fcu_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [7:0] wdata,
   input  logic       busy,
   output mode_e      mode,
   output logic       err_ers,
   output logic       err_prg,
   output logic       start_ers,
   output logic       start_prg,
   output logic       abort
);
   logic accept;

   assign accept    = wr_en && !busy;
   assign start_ers = accept && (mode == M_ERS_SETUP) && (wdata == CMD_ERS_CONF);
   assign abort     = accept && (mode == M_ERS_SETUP) && (wdata != CMD_ERS_CONF);
   assign start_prg = accept && (mode == M_PRG_SETUP);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode    <= M_ARRAY;
         err_ers <= 1'b0;
         err_prg <= 1'b0;
      end else if (accept) begin
         case (mode)
            M_ERS_SETUP: begin
               mode <= M_STATUS;
               if (wdata != CMD_ERS_CONF) begin
                  err_ers <= 1'b1;
                  err_prg <= 1'b1;
               end
            end
            M_PRG_SETUP: mode <= M_STATUS;
            default: begin
               case (wdata)
                  CMD_TO_ARRAY:  mode <= M_ARRAY;
                  CMD_TO_ID:     mode <= M_ID;
                  CMD_TO_STATUS: mode <= M_STATUS;
                  CMD_ERS_SETUP: mode <= M_ERS_SETUP;
                  CMD_PRG_SETUP: mode <= M_PRG_SETUP;
                  CMD_CLR_ERR: begin
                     err_ers <= 1'b0;
                     err_prg <= 1'b0;
                  end
                  default: ;
               endcase
            end
         endcase
      end
   end
endmodule

// File: rtl/fcu_busy_tmr.sv
module fcu_busy_tmr #(
   parameter int PROG_CYC  = 16,
   parameter int ERASE_CYC = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_prg,
   input  logic start_ers,
   output logic busy
);
   localparam int MAX_CYC = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
   localparam int CNT_W   = $clog2(MAX_CYC + 1);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)          cnt <= '0;
      else if (start_ers)  cnt <= CNT_W'(ERASE_CYC);
      else if (start_prg)  cnt <= CNT_W'(PROG_CYC);
      else if (cnt != '0)  cnt <= cnt - CNT_W'(1);
   end

   assign busy = (cnt != '0);
endmodule

// File: rtl/fcu_array.sv
module fcu_array #(
   parameter int ADDR_W = 8,
   parameter int SECT_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   input  logic              start_prg,
   input  logic              start_ers,
   output logic [7:0]        rd_byte
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [7:0] mem [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_cell
      localparam logic [ADDR_W-1:0] IDX = ADDR_W'(i);
      logic hit_sector;
      assign hit_sector = ((IDX >> SECT_W) == (addr >> SECT_W));
      always_ff @(posedge clk) begin
         if (!rst_n)                      mem[i] <= 8'hFF;
         else if (start_ers && hit_sector) mem[i] <= 8'hFF;
         else if (start_prg && addr == IDX) mem[i] <= mem[i] & wdata;
      end
   end

   assign rd_byte = mem[addr];
endmodule

// File: rtl/flash_cmd_ui.sv
module flash_cmd_ui
   import fcu_pkg::*;
#(
   parameter int         ADDR_W         = 8,
   parameter int         SECT_W         = 5,
   parameter int         PROG_CYC       = 16,
   parameter int         ERASE_CYC      = 64,
   parameter logic [7:0] MFR_ID         = 8'hBF,
   parameter logic [7:0] DEV_ID         = 8'h51,
   parameter bit         ID_FULL_DECODE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   input  logic              wr_en,
   input  logic              rd_en,
   output logic [7:0]        rdata
);
   if (ADDR_W < 2 || ADDR_W > 12) begin : g_bad_addr
      $error("flash_cmd_ui: ADDR_W out of range");
   end
   if (SECT_W < 1 || SECT_W >= ADDR_W) begin : g_bad_sect
      $error("flash_cmd_ui: SECT_W must lie in 1..ADDR_W-1");
   end
   if (PROG_CYC < 1 || ERASE_CYC < 1) begin : g_bad_cyc
      $error("flash_cmd_ui: busy times must be at least one cycle");
   end

   mode_e      mode;
   logic       busy, err_ers, err_prg, start_ers, start_prg, abort;
   logic [7:0] arr_byte, id_byte, status, view;

   fcu_cmd_dec u_dec (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata), .busy(busy),
      .mode(mode), .err_ers(err_ers), .err_prg(err_prg),
      .start_ers(start_ers), .start_prg(start_prg), .abort(abort)
   );

   fcu_busy_tmr #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_tmr (
      .clk(clk), .rst_n(rst_n), .start_prg(start_prg), .start_ers(start_ers),
      .busy(busy)
   );

   fcu_array #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_arr (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
      .start_prg(start_prg), .start_ers(start_ers), .rd_byte(arr_byte)
   );

   if (ID_FULL_DECODE) begin : g_id_full
      always_comb begin
         if (addr == ADDR_W'(0))      id_byte = MFR_ID;
         else if (addr == ADDR_W'(1)) id_byte = DEV_ID;
         else                         id_byte = 8'h00;
      end
   end else begin : g_id_lsb
      assign id_byte = addr[0] ? DEV_ID : MFR_ID;
   end

   assign status = {~busy, err_ers, 4'b0000, err_prg, 1'b0};

   always_comb begin
      if (busy) view = status;
      else begin
         case (mode)
            M_ARRAY: view = arr_byte;
            M_ID:    view = id_byte;
            default: view = status;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     rdata <= 8'h00;
      else if (rd_en) rdata <= view;
   end
endmodule

// File: rtl/fcu_chk.sv
module fcu_chk
   import fcu_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       wr_en,
   input logic [7:0] wdata,
   input logic       rd_en,
   input logic [7:0] rdata,
   input logic       busy,
   input mode_e      mode,
   input logic       err_ers,
   input logic       err_prg,
   input logic       abort,
   input logic       start_prg
);
   AST_BUSY_READ_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      busy && rd_en |=> !rdata[7]); // R8

   AST_BUSY_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
      busy && wr_en |=> $stable(mode) && $stable(err_ers) && $stable(err_prg)); // R8

   AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rdata)); // R13

   AST_ERR_CLEAR_BY_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(err_ers) || $fell(err_prg)) |-> $past(wr_en && !busy && wdata == 8'h50)); // R10

   AST_ABORT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> err_ers && err_prg && mode == M_STATUS); // R9

   AST_PROG_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      start_prg |=> busy); // R7
endmodule

bind flash_cmd_ui fcu_chk u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata), .rd_en(rd_en),
   .rdata(rdata), .busy(busy), .mode(mode), .err_ers(err_ers),
   .err_prg(err_prg), .abort(abort), .start_prg(start_prg)
);

// File: tb/tb_flash_cmd_ui.sv
module tb_flash_cmd_ui;
   localparam int         AW   = 8;
   localparam int         SW   = 5;
   localparam int         PCYC = 16;
   localparam int         ECYC = 64;
   localparam logic [7:0] MFR  = 8'hBF;
   localparam logic [7:0] DEV  = 8'h51;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [7:0]    wdata = 8'h00;
   logic          wr_en = 1'b0;
   logic          rd_en = 1'b0;
   logic [7:0]    rdata;

   always #4 clk = ~clk;

   flash_cmd_ui #(.ADDR_W(AW), .SECT_W(SW), .PROG_CYC(PCYC), .ERASE_CYC(ECYC),
                  .MFR_ID(MFR), .DEV_ID(DEV)) dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
      .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata));

   // behavioural reference model; mode codes 0 array,1 id,2 status,3 erase setup,4 program setup
   logic [7:0] m_mem [256];
   int         m_mode, m_cnt;
   bit         m_ee, m_pe;
   logic [7:0] exp_rd;
   int         vectors = 0, errors = 0;
   string      cur_req = "R1";
   bit         done = 1'b0;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < 256; k++) m_mem[k] = 8'hFF;
         m_mode = 0; m_cnt = 0; m_ee = 0; m_pe = 0; exp_rd = 8'h00;
      end else begin
         bit         bsy, started;
         logic [7:0] st;
         bsy = (m_cnt != 0);
         started = 0;
         st = {!bsy, m_ee, 4'b0000, m_pe, 1'b0};
         if (rd_en) begin
            if (bsy)              exp_rd = st;
            else if (m_mode == 0) exp_rd = m_mem[addr];
            else if (m_mode == 1) exp_rd = (addr == 0) ? MFR : (addr == 1) ? DEV : 8'h00;
            else                  exp_rd = st;
         end
         if (wr_en && !bsy) begin
            if (m_mode == 3) begin
               if (wdata == 8'hD0) begin
                  for (int k = 0; k < 256; k++)
                     if ((k >> SW) == (int'(addr) >> SW)) m_mem[k] = 8'hFF;
                  m_cnt = ECYC; started = 1;
               end else begin
                  m_ee = 1; m_pe = 1;
               end
               m_mode = 2;
            end else if (m_mode == 4) begin
               m_mem[addr] = m_mem[addr] & wdata;
               m_cnt = PCYC; started = 1; m_mode = 2;
            end else begin
               case (wdata)
                  8'hFF: m_mode = 0;
                  8'h90: m_mode = 1;
                  8'h70: m_mode = 2;
                  8'h30: m_mode = 3;
                  8'h10: m_mode = 4;
                  8'h50: begin m_ee = 0; m_pe = 0; end
                  default: ;
               endcase
            end
         end
         if (!started && bsy) m_cnt = m_cnt - 1;
      end
   end

   always @(negedge clk) begin
      if (!done) begin
         vectors++;
         if (rdata !== exp_rd) begin
            errors++;
            $display("FAIL %s: rdata=%02h expected=%02h at %0t", cur_req, rdata, exp_rd, $time);
         end
      end
   end

   task automatic cyc(input bit w, input bit r, input logic [7:0] a, input logic [7:0] d);
      wr_en = w; rd_en = r; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0;
   endtask
   task automatic wr(input logic [7:0] a, input logic [7:0] d); cyc(1, 0, a, d); endtask
   task automatic rd(input logic [7:0] a); cyc(0, 1, a, 8'h00); endtask
   task automatic idle(input int n); for (int k = 0; k < n; k++) cyc(0, 0, 8'h00, 8'h00); endtask

   initial begin
      #(8 * 20000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cur_req = "R1"; rd(8'h00); rd(8'h7F); rd(8'hFF); wr(8'h00, 8'h70); rd(8'h00);
      cur_req = "R2"; wr(8'h33, 8'hFF); rd(8'h10);
      cur_req = "R6"; wr(8'h00, 8'h10); wr(8'h23, 8'hA5);
      cur_req = "R7"; for (int k = 0; k < PCYC + 2; k++) rd(8'(k));
      cur_req = "R6"; wr(8'h00, 8'hFF); rd(8'h23); rd(8'h22);
      wr(8'h00, 8'h10); wr(8'h23, 8'h3C); idle(PCYC); wr(8'h00, 8'hFF); rd(8'h23);
      wr(8'h00, 8'h10); wr(8'h45, 8'h0F); idle(PCYC);
      cur_req = "R8"; wr(8'h00, 8'h10); wr(8'h60, 8'h00); wr(8'h00, 8'hFF); rd(8'h60); rd(8'h01);
      idle(PCYC - 3);
      cur_req = "R8"; wr(8'h00, 8'h10); wr(8'h61, 8'hF0); idle(PCYC - 1);
      wr(8'h00, 8'h90); rd(8'h01);
      wr(8'h00, 8'h90); rd(8'h01);
      cur_req = "R5"; wr(8'h00, 8'h30); wr(8'h2E, 8'hD0);
      cur_req = "R7"; for (int k = 0; k < ECYC + 2; k++) rd(8'h2E);
      cur_req = "R5"; wr(8'h00, 8'hFF);
      for (int k = 8'h20; k < 8'h40; k += 3) rd(8'(k));
      rd(8'h23); rd(8'h1F); rd(8'h45);
      cur_req = "R9"; wr(8'h00, 8'h30); wr(8'h45, 8'h70); rd(8'h45);
      wr(8'h00, 8'hFF); rd(8'h45);
      cur_req = "R10"; wr(8'h00, 8'h10); wr(8'h50, 8'h81); idle(PCYC); rd(8'h00);
      wr(8'h00, 8'hFF); wr(8'h00, 8'h50); rd(8'h50); wr(8'h00, 8'h70); rd(8'h00);
      cur_req = "R3"; wr(8'h00, 8'h90); rd(8'h00); rd(8'h01); rd(8'h02); rd(8'hC1);
      cur_req = "R11"; wr(8'h00, 8'h42); rd(8'h01); wr(8'h00, 8'hD0); rd(8'h00);
      cur_req = "R12"; cyc(1, 1, 8'h01, 8'hFF); rd(8'h01); cyc(1, 1, 8'h45, 8'h70); rd(8'h45);
      cur_req = "R13"; idle(5); wr(8'h00, 8'hFF); idle(3); rd(8'h45);
      cur_req = "R4"; wr(8'h00, 8'h30); rd(8'h00); wr(8'h00, 8'h00); rd(8'h00);
      wr(8'h00, 8'h50); rd(8'h00);
      idle(2);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule